// File: doc/BRIEF.md
# Banked 24-Bit Effective Address Generator

This block turns the pieces of an access into the 24-bit address driven onto the memory bus. The requester supplies an access class together with every candidate source: the program counter, a 16-bit base address, a 16-bit index, the direct page base, the stack pointer, the program bank, the data bank and an explicit bank for long accesses. The class picks which sources take part and where bits 23:16 come from. The block also raises a one-cycle penalty flag when a direct page access runs from a base that is not aligned to a 256-byte page.

Program fetches stay inside the program bank when the counter wraps. Indexed data accesses may cross into the next bank for that access alone. Direct page and stack accesses always land in bank zero. Long accesses bring their own bank and take no notice of the data bank. The result is registered once: the address and flag appear on the clock edge after the request, tagged by a valid bit. The block stores no bank registers of its own. The program and data banks are inputs, and their reset value of zero is held by whoever owns them. There is no state machine: one pipeline register follows the combinational selection.

Top module: `bank_addr_gen`

## Requirements
- R1: While rst_n is low and after its release, out_valid, out_addr and out_dp_penalty are all zero until the first accepted request.
- R2: With acc_class = 0 (fetch) the address is {pbr, pc}. A counter of 0xFFFF produces bank pbr, never pbr+1, and idx does not take part.
- R3: With acc_class = 1 (data) the address is ({dbr, 16'h0000} + base + idx) modulo 2^24, so a carry out of bit 15 raises the bank by one for that access only.
- R4: With acc_class = 4 (long) the address is ({long_bank, base} + idx) modulo 2^24, and dbr has no effect.
- R5: With acc_class = 2 (direct page) the address is {8'h00, (dp + base[7:0] + idx) modulo 2^16}. The upper byte of base has no effect.
- R6: With acc_class = 3 (stack) the address is {8'h00, sp}, and base and idx have no effect.
- R7: out_dp_penalty is 1 exactly when the accepted request had acc_class = 2 and dp[7:0] was nonzero. Otherwise it is 0.
- R8: An accepted request (in_valid = 1) appears on the outputs one clock later with out_valid = 1. A cycle with in_valid = 0 gives out_valid = 0 and out_dp_penalty = 0 on the next clock, and out_addr keeps its previous value.
- R9: The unused class codes 5, 6 and 7 form the address exactly as the data class does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| in_valid | input | 1 | A request is presented this cycle |
| acc_class | input | 3 | Access class: 0 fetch, 1 data, 2 direct page, 3 stack, 4 long |
| pc | input | 16 | Program counter |
| base | input | 16 | Base address, or the direct page offset in its low byte |
| idx | input | 16 | Index added to data, long and direct page addresses |
| dp | input | 16 | Direct page base |
| sp | input | 16 | Stack pointer |
| pbr | input | 8 | Program bank |
| dbr | input | 8 | Data bank |
| long_bank | input | 8 | Bank carried by a long access |
| out_valid | output | 1 | out_addr and out_dp_penalty belong to a request |
| out_addr | output | 24 | Formed bus address |
| out_dp_penalty | output | 1 | The access needs one extra cycle for misaligned direct page |

## Verification
The assertions assume that rst_n is held low for at least one clock before requests start, and that the inputs of a request stay steady across the edge that captures it. The bench changes inputs only on falling edges and keeps in_valid low during reset, so both assumptions hold. The sweep crosses every class code with base and index values at the 16-bit wrap points and with extreme bank values. This drives the bank carry, the fetch wrap and the bank-zero cases through the same edges that the bank assertions watch.

// File: rtl/bag_pkg.sv
package bag_pkg;

    typedef enum logic [2:0] {
        CLS_FETCH  = 3'd0,
        CLS_DATA   = 3'd1,
        CLS_DIRECT = 3'd2,
        CLS_STACK  = 3'd3,
        CLS_LONG   = 3'd4
    } acc_class_e;

endpackage

// File: rtl/bag_direct_calc.sv
module bag_direct_calc #(
    parameter int ADDR_W = 16,
    parameter int DPO_W  = 8
) (
    input  logic [ADDR_W-1:0] dp,
    input  logic [DPO_W-1:0]  offset,
    input  logic [ADDR_W-1:0] idx,
    output logic [ADDR_W-1:0] dp_addr,
    output logic              misaligned
);

    // Sum wraps within the low 16 bits; bank is forced elsewhere.
    always_comb begin
        dp_addr    = dp + ADDR_W'(offset) + idx;
        misaligned = (dp[DPO_W-1:0] != '0);
    end

endmodule

// File: rtl/bag_addr_mux.sv
module bag_addr_mux
    import bag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter int DPO_W  = 8,
    localparam int FULL_W = ADDR_W + BANK_W
) (
    input  logic [2:0]        acc_class,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx,
    input  logic [ADDR_W-1:0] dp,
    input  logic [ADDR_W-1:0] sp,
    input  logic [BANK_W-1:0] pbr,
    input  logic [BANK_W-1:0] dbr,
    input  logic [BANK_W-1:0] long_bank,
    output logic [FULL_W-1:0] addr,
    output logic              dp_penalty
);

    logic [ADDR_W-1:0] dp_addr;
    logic              dp_misaligned;
    logic [FULL_W-1:0] data_sum;
    logic [FULL_W-1:0] long_sum;
    logic              unused_base_hi;

    assign unused_base_hi = ^base[ADDR_W-1:DPO_W];

    bag_direct_calc #(
        .ADDR_W (ADDR_W),
        .DPO_W  (DPO_W)
    ) u_direct (
        .dp         (dp),
        .offset     (base[DPO_W-1:0]),
        .idx        (idx),
        .dp_addr    (dp_addr),
        .misaligned (dp_misaligned)
    );

    // Full-width sums so the carry out of the offset reaches the bank.
    always_comb begin
        data_sum = {dbr, {ADDR_W{1'b0}}} + FULL_W'(base) + FULL_W'(idx);
        long_sum = {long_bank, base} + FULL_W'(idx);
    end

    always_comb begin
        dp_penalty = 1'b0;
        case (acc_class)
            CLS_FETCH:  addr = {pbr, pc};
            CLS_DIRECT: begin
                addr       = {{BANK_W{1'b0}}, dp_addr};
                dp_penalty = dp_misaligned;
            end
            CLS_STACK:  addr = {{BANK_W{1'b0}}, sp};
            CLS_LONG:   addr = long_sum;
            default:    addr = data_sum;
        endcase
    end

endmodule

// File: rtl/bag_stage.sv
module bag_stage #(
    parameter int FULL_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FULL_W-1:0] addr_d,
    input  logic              pen_d,
    output logic              out_valid,
    output logic [FULL_W-1:0] addr_q,
    output logic              pen_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            addr_q    <= '0;
            pen_q     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            pen_q     <= in_valid & pen_d;
            if (in_valid) begin
                addr_q <= addr_d;
            end
        end
    end

    // R8: valid follows the request by one cycle
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !pen_q && $stable(addr_q)));

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter int DPO_W  = 8,
    parameter bit REGISTERED = 1'b1,
    localparam int FULL_W = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        acc_class,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx,
    input  logic [ADDR_W-1:0] dp,
    input  logic [ADDR_W-1:0] sp,
    input  logic [BANK_W-1:0] pbr,
    input  logic [BANK_W-1:0] dbr,
    input  logic [BANK_W-1:0] long_bank,
    output logic              out_valid,
    output logic [FULL_W-1:0] out_addr,
    output logic              out_dp_penalty
);

    logic [FULL_W-1:0] addr_c;
    logic              pen_c;

    bag_addr_mux #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .DPO_W  (DPO_W)
    ) u_mux (
        .acc_class  (acc_class),
        .pc         (pc),
        .base       (base),
        .idx        (idx),
        .dp         (dp),
        .sp         (sp),
        .pbr        (pbr),
        .dbr        (dbr),
        .long_bank  (long_bank),
        .addr       (addr_c),
        .dp_penalty (pen_c)
    );

    generate
        if (REGISTERED) begin : g_reg
            bag_stage #(
                .FULL_W (FULL_W)
            ) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (in_valid),
                .addr_d    (addr_c),
                .pen_d     (pen_c),
                .out_valid (out_valid),
                .addr_q    (out_addr),
                .pen_q     (out_dp_penalty)
            );

            // R2: fetch keeps the program bank even when pc wraps
            p_fetch_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && acc_class == CLS_FETCH) |=>
                    (out_addr == {$past(pbr), $past(pc)}));
            // R3: data bank may rise by at most one through index carry
            p_data_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && acc_class == CLS_DATA) |=>
                    (out_addr[FULL_W-1:ADDR_W] == $past(dbr) ||
                     out_addr[FULL_W-1:ADDR_W] == BANK_W'($past(dbr) + 1'b1)));
            // R5: direct page lands in bank zero
            p_direct_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && acc_class == CLS_DIRECT) |=>
                    (out_addr[FULL_W-1:ADDR_W] == '0));
            // R6: stack lands in bank zero at the stack pointer
            p_stack_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && acc_class == CLS_STACK) |=>
                    (out_addr == {{BANK_W{1'b0}}, $past(sp)}));
            // R7: penalty only for a direct page request
            p_penalty_r7: assert property (@(posedge clk) disable iff (!rst_n)
                out_dp_penalty |-> (out_valid && $past(acc_class) == CLS_DIRECT));
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk     = clk ^ rst_n;
            assign out_valid      = in_valid;
            assign out_addr       = addr_c;
            assign out_dp_penalty = in_valid & pen_c;
        end
    endgenerate

endmodule

// File: tb/bank_addr_gen_bench.sv
module bank_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  acc_class = '0;
    logic [15:0] pc = '0, base = '0, idx = '0, dp = '0, sp = '0;
    logic [7:0]  pbr = '0, dbr = '0, long_bank = '0;
    logic        out_valid;
    logic [23:0] out_addr;
    logic        out_dp_penalty;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bank_addr_gen u_bank_addr_gen (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .acc_class (acc_class), .pc (pc), .base (base), .idx (idx),
        .dp (dp), .sp (sp), .pbr (pbr), .dbr (dbr), .long_bank (long_bank),
        .out_valid (out_valid), .out_addr (out_addr),
        .out_dp_penalty (out_dp_penalty)
    );

    function automatic string req_of(int cls);
        case (cls)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            4: return "R4";
            default: return "R9";
        endcase
    endfunction

    function automatic int exp_addr(int cls);
        case (cls)
            0: return (int'(pbr) << 16) | int'(pc);
            2: return (int'(dp) + int'(base[7:0]) + int'(idx)) & 32'hFFFF;
            3: return int'(sp);
            4: return ((int'(long_bank) << 16) + int'(base) + int'(idx)) & 32'hFFFFFF;
            default: return ((int'(dbr) << 16) + int'(base) + int'(idx)) & 32'hFFFFFF;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [6];
        logic [7:0]  banks [3];
        logic [15:0] dps [3];
        int          ea;
        int          ep;
        logic [23:0] held;
        vals  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFF00, 16'hFFFF};
        banks = '{8'h00, 8'h7F, 8'hFF};
        dps   = '{16'h0000, 16'h1234, 16'hFF00};

        repeat (3) @(negedge clk);
        // R1: outputs clear under reset
        check("R1", "valid in reset", int'(out_valid), 0);
        check("R1", "addr in reset", int'(out_addr), 0);
        check("R1", "penalty in reset", int'(out_dp_penalty), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "addr after release", int'(out_addr), 0);
        check("R1", "valid after release", int'(out_valid), 0);

        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 6; b++) begin
                for (int i = 0; i < 6; i++) begin
                    for (int k = 0; k < 3; k++) begin
                        for (int d = 0; d < 3; d++) begin
                            acc_class = 3'(c);
                            base      = vals[b];
                            idx       = vals[i];
                            pc        = vals[i];
                            sp        = 16'h01FF ^ vals[b] ^ {8'h00, banks[k]};
                            dp        = dps[d];
                            pbr       = banks[k];
                            dbr       = banks[k] ^ 8'h5A;
                            long_bank = banks[k] ^ 8'hA5;
                            in_valid  = 1'b1;
                            ea = exp_addr(c);
                            ep = (c == 2 && dps[d][7:0] != 8'h00) ? 1 : 0;
                            @(negedge clk);
                            check(req_of(c), "address", int'(out_addr), ea);
                            check("R7", "penalty", int'(out_dp_penalty), ep);
                            check("R8", "valid", int'(out_valid), 1);
                        end
                    end
                end
            end
        end

        // R8: idle cycle keeps the address and drops valid and penalty
        acc_class = 3'd2; dp = 16'h0101; base = 16'h0010; idx = 16'h0000;
        in_valid = 1'b1;
        @(negedge clk);
        held = out_addr;
        check("R7", "penalty before idle", int'(out_dp_penalty), 1);
        in_valid = 1'b0; acc_class = 3'd1; base = 16'hABCD; dbr = 8'h33;
        @(negedge clk);
        check("R8", "idle valid", int'(out_valid), 0);
        check("R8", "idle penalty", int'(out_dp_penalty), 0);
        check("R8", "idle address held", int'(out_addr), int'(held));

        // R4: long ignores dbr (same request, dbr changed)
        acc_class = 3'd4; long_bank = 8'h12; base = 16'hFFFF; idx = 16'h0002;
        dbr = 8'h00; in_valid = 1'b1;
        @(negedge clk);
        check("R4", "long crosses bank", int'(out_addr), 32'h130001);
        dbr = 8'hEE;
        @(negedge clk);
        check("R4", "long dbr ignored", int'(out_addr), 32'h130001);

        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule